// File: doc/BRIEF.md
# Shared-Memory Multi-Slice FIFO Controller

This block keeps the transmit and receive queues of a bank of serial channels in one single-port memory of 1024 words of 32 bits. The memory is carved into 24 slices: for channel `c`, slice `2c` is its transmit queue and slice `2c+1` its receive queue. Each slice is a circular buffer inside a window that software places with a base address and a size. Each slice has its own read and write offsets, a fill count, an alarm threshold, sticky error flags and an interrupt mask. Hardware does not check whether two windows overlap; software has to keep them apart.

Channel logic pops transmit words and pushes receive words through a request vector. A host port reads and writes slice data and slice registers. The one memory port is shared through a fixed-priority arbiter that serves one access per cycle. Channel requests always win over the host. A per-channel interrupt vector is driven as an output and can also be read through the host port.

Host addresses are `{slice[4:0], reg[3:0]}`. The register indices are: 0 command, 1 alarm, 2 status, 3 interrupt status, 4 interrupt mask, 5 count, 6 offsets, 7 window, 8 data. Slice field 31 with register 0 returns the per-channel interrupt vector.

Top module: `mfifo_ctrl`

## Requirements
- R1: After reset every slice has size 0, count 0 and mask 0, `irq_ch` is 0, and no response is valid. The status register (index 2: bit0 empty, bit1 full, bit2 alarm) of a receive slice reads 7.
- R2: Words leave a slice in the order they entered. Offsets wrap from size-1 back to 0, and physical addresses are base+offset modulo 1024.
- R3: The count (index 5) follows pushes and pops. Status bit1 (full) is set when count equals size, and bit0 (empty) is set when count is 0.
- R4: A push into a full slice sets interrupt-status bit1 and leaves the count and the stored words unchanged.
- R5: A pop from an empty slice sets interrupt-status bit2. A host data read then returns 0, and a channel pop gives no `ch_rvalid`.
- R6: Status bit2 and interrupt-status bit0 hold the live alarm condition. For a transmit (even) slice the condition is count <= alarm (index 1). For a receive (odd) slice it is count >= alarm.
- R7: `irq_ch[c]` is set when slice 2c or slice 2c+1 has any bit of (interrupt status & mask) set, where the mask is index 4, bits 2:0. A host read of address 0x1F0 returns `irq_ch`.
- R8: Writing 1 to interrupt-status bit1 or bit2 clears that bit. Writing 0 has no effect.
- R9: Writing bit0 = 1 to the command register (index 0) clears both offsets, the count and the error flags, and keeps base and size.
- R10: A write to the offsets register (index 6) loads wdata[9:0] into both offsets, or 0 if that value is not below the size, and clears the count. Reading index 6 returns the read offset in bits 25:16 and the write offset in bits 9:0.
- R11: At most one request is granted per cycle. The lowest set bit of `ch_req` wins (bit 2c is a pop of channel c, bit 2c+1 is a push of channel c). The host is granted only when `ch_req` is 0.
- R12: A granted channel pop of a non-empty slice gives `ch_rvalid`, the channel number and the word in the next cycle. A channel push lands in the receive slice of that channel.
- R13: The window register (index 7) holds the base in bits 9:0 and the size in bits 26:16. A written size above 1024 becomes 1024, and the write also clears the offsets, count and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_req | input | 24 | Bit 2c: pop transmit slice of channel c; bit 2c+1: push into receive slice of channel c |
| ch_wdata | input | 384 | Push word of channel c at bits 32c+31:32c |
| ch_gnt | output | 24 | One-hot grant of `ch_req` |
| ch_rvalid | output | 1 | Popped word valid (cycle after grant) |
| ch_rch | output | 4 | Channel of the popped word |
| ch_rdata | output | 32 | Popped word |
| host_req | input | 1 | Host access request, held until granted |
| host_we | input | 1 | Host write when 1 |
| host_addr | input | 9 | {slice, register index} |
| host_wdata | input | 32 | Host write data |
| host_gnt | output | 1 | Host access accepted this cycle |
| host_rvalid | output | 1 | Response valid, cycle after grant |
| host_rdata | output | 32 | Host read data |
| irq_ch | output | 12 | Per-channel pending interrupt |

## Verification
Host access and channel traffic can both ask for the single memory port in the same cycle. The bench raises a channel push, a channel pop and a host read together. It then checks that the grants fall one per cycle in priority order, that the host waits until the channel bits drop, and that each response appears one cycle after its own grant with the right data. The same sequence shows a channel pop and an alarm-driven interrupt changing in one cycle, and `irq_ch` is checked at that point.

// File: rtl/mfifo_pkg.sv
package mfifo_pkg;
    localparam int unsigned DEF_N_CH  = 12;
    localparam int unsigned DEF_DW    = 32;
    localparam int unsigned DEF_DEPTH = 1024;
    localparam int unsigned REG_W     = 4;
    localparam int unsigned SZ_LSB    = 16;

    typedef enum logic [REG_W-1:0] {
        REG_CMD   = 4'd0,
        REG_ALARM = 4'd1,
        REG_STAT  = 4'd2,
        REG_ISR   = 4'd3,
        REG_IMR   = 4'd4,
        REG_COUNT = 4'd5,
        REG_PTR   = 4'd6,
        REG_SIZE  = 4'd7,
        REG_DATA  = 4'd8
    } reg_e;
endpackage

// File: rtl/mfifo_ram.sv
module mfifo_ram #(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int unsigned WORDS = 1 << AW;

    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (en && we) begin
            mem_q[addr] <= wdata;
        end
        if (en && !we) begin
            rdata <= mem_q[addr];
        end
    end
endmodule

// File: rtl/mfifo_arb.sv
module mfifo_arb #(
    parameter int unsigned N = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic taken;

    // Lowest index wins; the host sits in the top bit.
    always_comb begin
        gnt   = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

    a_r11_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    a_r11_no_lower_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |-> (((gnt - 1'b1) & req) == '0));
    a_r11_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (gnt != '0));
endmodule

// File: rtl/mfifo_slice.sv
module mfifo_slice
    import mfifo_pkg::*;
#(
    parameter int unsigned AW    = 10,
    parameter int unsigned DW    = 32,
    parameter bit          IS_TX = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             cfg_we_i,
    input  logic [REG_W-1:0] cfg_sel_i,
    input  logic [DW-1:0]    cfg_wdata_i,
    output logic [AW-1:0]    wr_addr_o,
    output logic [AW-1:0]    rd_addr_o,
    output logic             full_o,
    output logic             empty_o,
    output logic [DW-1:0]    rdreg_o,
    output logic             irq_o
);
    localparam int unsigned CW    = AW + 1;
    localparam int unsigned DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [CW-1:0] size;
        logic [AW-1:0] rdoff;
        logic [AW-1:0] wroff;
        logic [CW-1:0] count;
        logic [CW-1:0] alarm;
        logic          ovf;
        logic          udf;
        logic [2:0]    mask;
    } st_t;

    st_t s_d, s_q;

    logic          alarm_live;
    logic [2:0]    isr;
    logic [CW-1:0] new_sz;
    logic [AW-1:0] new_off;
    logic          unused_wdata;

    assign unused_wdata = ^cfg_wdata_i;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] off, input logic [CW-1:0] sz);
        if (({1'b0, off} + CW'(1)) >= sz) begin
            return '0;
        end
        return off + AW'(1);
    endfunction

    assign full_o     = (s_q.count == s_q.size);
    assign empty_o    = (s_q.count == '0);
    assign alarm_live = IS_TX ? (s_q.count <= s_q.alarm) : (s_q.count >= s_q.alarm);
    assign isr        = {s_q.udf, s_q.ovf, alarm_live};
    assign irq_o      = |(isr & s_q.mask);
    assign wr_addr_o  = s_q.base + s_q.wroff;
    assign rd_addr_o  = s_q.base + s_q.rdoff;

    always_comb begin
        s_d     = s_q;
        new_sz  = cfg_wdata_i[SZ_LSB +: CW];
        new_off = cfg_wdata_i[AW-1:0];
        if (new_sz > CW'(DEPTH)) begin
            new_sz = CW'(DEPTH);
        end

        if (push_i) begin
            if (full_o) begin
                s_d.ovf = 1'b1;
            end else begin
                s_d.wroff = step(s_q.wroff, s_q.size);
                s_d.count = s_q.count + CW'(1);
            end
        end

        if (pop_i) begin
            if (empty_o) begin
                s_d.udf = 1'b1;
            end else begin
                s_d.rdoff = step(s_q.rdoff, s_q.size);
                s_d.count = s_q.count - CW'(1);
            end
        end

        if (cfg_we_i) begin
            case (cfg_sel_i)
                REG_CMD: begin
                    if (cfg_wdata_i[0]) begin
                        s_d.rdoff = '0;
                        s_d.wroff = '0;
                        s_d.count = '0;
                        s_d.ovf   = 1'b0;
                        s_d.udf   = 1'b0;
                    end
                end
                REG_ALARM: s_d.alarm = cfg_wdata_i[CW-1:0];
                REG_ISR: begin
                    if (cfg_wdata_i[1]) s_d.ovf = 1'b0;
                    if (cfg_wdata_i[2]) s_d.udf = 1'b0;
                end
                REG_IMR: s_d.mask = cfg_wdata_i[2:0];
                REG_PTR: begin
                    if ({1'b0, new_off} < s_q.size) begin
                        s_d.rdoff = new_off;
                        s_d.wroff = new_off;
                    end else begin
                        s_d.rdoff = '0;
                        s_d.wroff = '0;
                    end
                    s_d.count = '0;
                end
                REG_SIZE: begin
                    s_d.base  = cfg_wdata_i[AW-1:0];
                    s_d.size  = new_sz;
                    s_d.rdoff = '0;
                    s_d.wroff = '0;
                    s_d.count = '0;
                    s_d.ovf   = 1'b0;
                    s_d.udf   = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdreg_o = '0;
        case (cfg_sel_i)
            REG_ALARM: rdreg_o[CW-1:0] = s_q.alarm;
            REG_STAT:  rdreg_o[2:0]    = {alarm_live, full_o, empty_o};
            REG_ISR:   rdreg_o[2:0]    = isr;
            REG_IMR:   rdreg_o[2:0]    = s_q.mask;
            REG_COUNT: rdreg_o[CW-1:0] = s_q.count;
            REG_PTR: begin
                rdreg_o[SZ_LSB +: AW] = s_q.rdoff;
                rdreg_o[AW-1:0]       = s_q.wroff;
            end
            REG_SIZE: begin
                rdreg_o[SZ_LSB +: CW] = s_q.size;
                rdreg_o[AW-1:0]       = s_q.base;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= s_q.size);
    a_r2_offsets_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.size != '0) |-> ((s_q.rdoff < s_q.size) && (s_q.wroff < s_q.size)));
    a_r4_full_push_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o) |=> (s_q.ovf && (s_q.count == $past(s_q.count))));
    a_r5_empty_pop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o) |=> (s_q.udf && (s_q.count == '0)));
    a_r9_cmd_keeps_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && (cfg_sel_i == REG_CMD) && cfg_wdata_i[0])
            |=> ((s_q.count == '0) && $stable(s_q.base) && $stable(s_q.size)));
endmodule

// File: rtl/mfifo_ctrl.sv
module mfifo_ctrl
    import mfifo_pkg::*;
#(
    parameter int unsigned N_CH  = DEF_N_CH,
    parameter int unsigned DW    = DEF_DW,
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned N_SL = 2 * N_CH,
    localparam int unsigned SLW  = $clog2(N_SL),
    localparam int unsigned HAW  = SLW + REG_W,
    localparam int unsigned CHW  = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SL-1:0]   ch_req,
    input  logic [N_CH*DW-1:0] ch_wdata,
    output logic [N_SL-1:0]   ch_gnt,
    output logic              ch_rvalid,
    output logic [CHW-1:0]    ch_rch,
    output logic [DW-1:0]     ch_rdata,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [HAW-1:0]    host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic              host_gnt,
    output logic              host_rvalid,
    output logic [DW-1:0]     host_rdata,
    output logic [N_CH-1:0]   irq_ch
);
    localparam int unsigned AW     = $clog2(DEPTH);
    localparam int unsigned N_REQ  = N_SL + 1;
    localparam logic [SLW-1:0] GLOBAL_SL = '1;

    typedef struct packed {
        logic           h_rv;
        logic           h_ram;
        logic           h_ok;
        logic [DW-1:0]  h_reg;
        logic           c_rv;
        logic [CHW-1:0] c_ch;
    } rsp_t;

    rsp_t r_d, r_q;

    logic [N_REQ-1:0] gnt_all;
    logic [N_SL-1:0]  push_v, pop_v, cfg_v, full_v, empty_v, irq_v, tx_gnt;
    logic [AW-1:0]    wr_addr [N_SL];
    logic [AW-1:0]    rd_addr [N_SL];
    logic [DW-1:0]    rdreg   [N_SL];
    logic [SLW-1:0]   h_slice;
    logic [REG_W-1:0] h_reg;
    logic             h_in_range;
    logic             ram_en, ram_we;
    logic [AW-1:0]    ram_addr;
    logic [DW-1:0]    ram_wdata, ram_rdata;

    mfifo_arb #(.N(N_REQ)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   ({host_req, ch_req}),
        .gnt   (gnt_all)
    );

    assign ch_gnt     = gnt_all[N_SL-1:0];
    assign host_gnt   = gnt_all[N_SL];
    assign h_slice    = host_addr[REG_W +: SLW];
    assign h_reg      = host_addr[REG_W-1:0];
    assign h_in_range = (h_slice < SLW'(N_SL));

    // Decode the single granted request into per-slice strobes.
    always_comb begin
        push_v    = '0;
        pop_v     = '0;
        cfg_v     = '0;
        tx_gnt    = '0;
        ram_wdata = host_wdata;
        for (int c = 0; c < N_CH; c++) begin
            if (ch_gnt[2*c]) begin
                pop_v[2*c]  = 1'b1;
                tx_gnt[2*c] = 1'b1;
            end
            if (ch_gnt[2*c+1]) begin
                push_v[2*c+1] = 1'b1;
                ram_wdata     = ch_wdata[c*DW +: DW];
            end
        end
        if (host_gnt && h_in_range) begin
            if (h_reg == REG_DATA) begin
                if (host_we) push_v[h_slice] = 1'b1;
                else         pop_v[h_slice]  = 1'b1;
            end else if (host_we) begin
                cfg_v[h_slice] = 1'b1;
            end
        end
    end

    always_comb begin
        ram_addr = '0;
        for (int s = 0; s < N_SL; s++) begin
            if (push_v[s]) ram_addr = wr_addr[s];
            if (pop_v[s])  ram_addr = rd_addr[s];
        end
        ram_we = |(push_v & ~full_v);
        ram_en = ram_we | (|(pop_v & ~empty_v));
    end

    mfifo_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    for (genvar s = 0; s < N_SL; s++) begin : g_slice
        mfifo_slice #(.AW(AW), .DW(DW), .IS_TX((s % 2) == 0)) u_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .push_i      (push_v[s]),
            .pop_i       (pop_v[s]),
            .cfg_we_i    (cfg_v[s]),
            .cfg_sel_i   (h_reg),
            .cfg_wdata_i (host_wdata),
            .wr_addr_o   (wr_addr[s]),
            .rd_addr_o   (rd_addr[s]),
            .full_o      (full_v[s]),
            .empty_o     (empty_v[s]),
            .rdreg_o     (rdreg[s]),
            .irq_o       (irq_v[s])
        );
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_irq
        assign irq_ch[c] = irq_v[2*c] | irq_v[2*c+1];
    end

    always_comb begin
        r_d       = r_q;
        r_d.h_rv  = host_gnt;
        r_d.h_ram = host_gnt && h_in_range && (h_reg == REG_DATA) && !host_we;
        r_d.h_ok  = h_in_range && !empty_v[h_slice];
        r_d.h_reg = '0;
        if (h_in_range) begin
            r_d.h_reg = rdreg[h_slice];
        end else if ((h_slice == GLOBAL_SL) && (h_reg == REG_CMD)) begin
            r_d.h_reg[N_CH-1:0] = irq_ch;
        end
        r_d.c_rv = 1'b0;
        for (int c = 0; c < N_CH; c++) begin
            if (tx_gnt[2*c] && !empty_v[2*c]) begin
                r_d.c_rv = 1'b1;
                r_d.c_ch = CHW'(c);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_rvalid = r_q.h_rv;
    assign host_rdata  = r_q.h_ram ? (r_q.h_ok ? ram_rdata : '0) : r_q.h_reg;
    assign ch_rvalid   = r_q.c_rv;
    assign ch_rch      = r_q.c_ch;
    assign ch_rdata    = ram_rdata;

    a_r11_host_after_channels: assert property (@(posedge clk) disable iff (!rst_n)
        host_gnt |-> (ch_req == '0));
    a_r12_pop_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tx_gnt & ~empty_v)) |=> ch_rvalid);
    a_r12_answer_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ch_rvalid |-> $past(|tx_gnt));
    a_r5_empty_pop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_gnt & ~empty_v) == '0) |=> !ch_rvalid);
endmodule

// File: tb/mfifo_ctrl_test.sv
module mfifo_ctrl_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [23:0]  ch_req = '0;
    logic [383:0] ch_wdata = '0;
    logic [23:0]  ch_gnt;
    logic         ch_rvalid;
    logic [3:0]   ch_rch;
    logic [31:0]  ch_rdata;
    logic         host_req = 1'b0;
    logic         host_we = 1'b0;
    logic [8:0]   host_addr = '0;
    logic [31:0]  host_wdata = '0;
    logic         host_gnt, host_rvalid;
    logic [31:0]  host_rdata;
    logic [11:0]  irq_ch;

    int total = 0;
    int bad = 0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    mfifo_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_wdata(ch_wdata),
        .ch_gnt(ch_gnt), .ch_rvalid(ch_rvalid), .ch_rch(ch_rch), .ch_rdata(ch_rdata),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_gnt(host_gnt), .host_rvalid(host_rvalid),
        .host_rdata(host_rdata), .irq_ch(irq_ch)
    );

    // {check, write, requirement, address, wdata, expected}
    localparam int NV = 29;
    localparam logic [78:0] VEC [NV] = '{
        {1'b0, 1'b1, 4'd13, 9'h037, 32'h000403FE, 32'h0},
        {1'b1, 1'b0, 4'd13, 9'h037, 32'h0,        32'h000403FE},
        {1'b1, 1'b0, 4'd6,  9'h032, 32'h0,        32'h5},
        {1'b0, 1'b1, 4'd6,  9'h031, 32'h3,        32'h0},
        {1'b1, 1'b0, 4'd6,  9'h032, 32'h0,        32'h1},
        {1'b0, 1'b1, 4'd2,  9'h038, 32'hA0,       32'h0},
        {1'b0, 1'b1, 4'd2,  9'h038, 32'hA1,       32'h0},
        {1'b0, 1'b1, 4'd2,  9'h038, 32'hA2,       32'h0},
        {1'b0, 1'b1, 4'd2,  9'h038, 32'hA3,       32'h0},
        {1'b1, 1'b0, 4'd3,  9'h035, 32'h0,        32'h4},
        {1'b1, 1'b0, 4'd3,  9'h032, 32'h0,        32'h6},
        {1'b0, 1'b1, 4'd4,  9'h038, 32'hA4,       32'h0},
        {1'b1, 1'b0, 4'd4,  9'h033, 32'h0,        32'h3},
        {1'b1, 1'b0, 4'd4,  9'h035, 32'h0,        32'h4},
        {1'b1, 1'b0, 4'd2,  9'h038, 32'h0,        32'hA0},
        {1'b1, 1'b0, 4'd2,  9'h038, 32'h0,        32'hA1},
        {1'b0, 1'b1, 4'd2,  9'h038, 32'hA5,       32'h0},
        {1'b0, 1'b1, 4'd2,  9'h038, 32'hA6,       32'h0},
        {1'b1, 1'b0, 4'd10, 9'h036, 32'h0,        32'h00020002},
        {1'b1, 1'b0, 4'd2,  9'h038, 32'h0,        32'hA2},
        {1'b1, 1'b0, 4'd2,  9'h038, 32'h0,        32'hA3},
        {1'b1, 1'b0, 4'd2,  9'h038, 32'h0,        32'hA5},
        {1'b1, 1'b0, 4'd2,  9'h038, 32'h0,        32'hA6},
        {1'b1, 1'b0, 4'd5,  9'h038, 32'h0,        32'h0},
        {1'b1, 1'b0, 4'd5,  9'h033, 32'h0,        32'h6},
        {1'b0, 1'b1, 4'd8,  9'h033, 32'h2,        32'h0},
        {1'b1, 1'b0, 4'd8,  9'h033, 32'h0,        32'h4},
        {1'b0, 1'b1, 4'd8,  9'h033, 32'h4,        32'h0},
        {1'b1, 1'b0, 4'd8,  9'h033, 32'h0,        32'h0}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_op(input logic we, input logic [8:0] a, input logic [31:0] wd,
                           output logic [31:0] rdv);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
        #1;
        while (!host_gnt) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        host_req = 1'b0;
        #1;
        rdv = host_rdata;
    endtask

    task automatic ch_op(input int bitn, input logic [31:0] wd);
        @(negedge clk);
        ch_req = '0;
        ch_req[bitn] = 1'b1;
        ch_wdata[(bitn/2)*32 +: 32] = wd;
        @(negedge clk);
        ch_req = '0;
        #1;
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(irq_ch == '0, "R1 irq", 32'(irq_ch), 32'h0);
        check(!ch_rvalid && !host_rvalid, "R1 rvalid", 32'({ch_rvalid, host_rvalid}), 32'h0);
        host_op(1'b0, 9'h005, 32'h0, rd);
        check(rd == 32'h0, "R1 count", rd, 32'h0);
        host_op(1'b0, 9'h057, 32'h0, rd);
        check(rd == 32'h0, "R1 size", rd, 32'h0);
        host_op(1'b0, 9'h012, 32'h0, rd);
        check(rd == 32'h7, "R1 status", rd, 32'h7);

        // Table: receive slice 3, window wraps the end of memory (R2 R3 R4 R5 R6 R8 R10 R13)
        for (int i = 0; i < NV; i++) begin
            host_op(VEC[i][77], VEC[i][72:64], VEC[i][63:32], rd);
            if (VEC[i][78]) begin
                check(rd == VEC[i][31:0], $sformatf("R%0d vec%0d", VEC[i][76:73], i), rd, VEC[i][31:0]);
            end
        end

        // R12: channel push lands in receive slice 1
        host_op(1'b1, 9'h017, 32'h00040010, rd);
        ch_op(1, 32'h55);
        host_op(1'b0, 9'h018, 32'h0, rd);
        check(rd == 32'h55, "R12 push path", rd, 32'h55);

        // R6: transmit slice 2 alarm when count <= level
        host_op(1'b1, 9'h027, 32'h00080040, rd);
        host_op(1'b1, 9'h021, 32'h1, rd);
        host_op(1'b0, 9'h023, 32'h0, rd);
        check(rd == 32'h1, "R6 tx alarm at 0", rd, 32'h1);
        host_op(1'b1, 9'h028, 32'hB0, rd);
        host_op(1'b1, 9'h028, 32'hB1, rd);
        host_op(1'b0, 9'h023, 32'h0, rd);
        check(rd == 32'h0, "R6 tx alarm off at 2", rd, 32'h0);
        host_op(1'b1, 9'h024, 32'h1, rd);
        #1;
        check(irq_ch == '0, "R7 masked quiet", 32'(irq_ch), 32'h0);

        // R11: push ch0, pop ch1 and host read collide
        @(negedge clk);
        ch_req = 24'h6;
        ch_wdata[31:0] = 32'h66;
        host_req = 1'b1; host_we = 1'b0; host_addr = 9'h015;
        #1;
        check((ch_gnt == 24'h2) && !host_gnt, "R11 first grant", 32'(ch_gnt), 32'h2);
        @(negedge clk);
        ch_req = 24'h4;
        #1;
        check((ch_gnt == 24'h4) && !host_gnt, "R11 second grant", 32'(ch_gnt), 32'h4);
        check(!ch_rvalid, "R12 no answer to push", 32'(ch_rvalid), 32'h0);
        @(negedge clk);
        ch_req = '0;
        #1;
        check(ch_rvalid && (ch_rch == 4'd1), "R12 pop valid/channel", {27'h0, ch_rvalid, ch_rch}, 32'h11);
        check(ch_rdata == 32'hB0, "R12 pop data", ch_rdata, 32'hB0);
        check(host_gnt, "R11 host served last", 32'(host_gnt), 32'h1);
        check(irq_ch == 12'h002, "R7 irq after pop", 32'(irq_ch), 32'h2);
        @(negedge clk);
        host_req = 1'b0;
        #1;
        check(host_rvalid && (host_rdata == 32'h1), "R3 count slice1", host_rdata, 32'h1);
        host_op(1'b0, 9'h1F0, 32'h0, rd);
        check(rd == 32'h2, "R7 global vector", rd, 32'h2);

        // R9: command reset of slice 2
        host_op(1'b1, 9'h020, 32'h1, rd);
        host_op(1'b0, 9'h025, 32'h0, rd);
        check(rd == 32'h0, "R9 count cleared", rd, 32'h0);
        host_op(1'b0, 9'h027, 32'h0, rd);
        check(rd == 32'h00080040, "R9 window kept", rd, 32'h00080040);
        host_op(1'b0, 9'h026, 32'h0, rd);
        check(rd == 32'h0, "R9 offsets cleared", rd, 32'h0);

        // R10: offset load on slice 1
        host_op(1'b1, 9'h016, 32'h3, rd);
        host_op(1'b0, 9'h016, 32'h0, rd);
        check(rd == 32'h00030003, "R10 offsets loaded", rd, 32'h00030003);
        host_op(1'b0, 9'h015, 32'h0, rd);
        check(rd == 32'h0, "R10 count cleared", rd, 32'h0);
        host_op(1'b1, 9'h016, 32'h9, rd);
        host_op(1'b0, 9'h016, 32'h0, rd);
        check(rd == 32'h0, "R10 out of window", rd, 32'h0);

        // R13: size clamp on slice 4
        host_op(1'b1, 9'h047, 32'h07FF0000, rd);
        host_op(1'b0, 9'h047, 32'h0, rd);
        check(rd == 32'h04000000, "R13 clamp", rd, 32'h04000000);

        // R5: channel pop of empty transmit slice 6
        ch_op(6, 32'h0);
        check(!ch_rvalid, "R5 no answer", 32'(ch_rvalid), 32'h0);
        host_op(1'b0, 9'h063, 32'h0, rd);
        check(rd == 32'h5, "R5 underflow flag", rd, 32'h5);

        finish_up();
    end
endmodule